// File: doc/BRIEF.md
# Radix-4 Two-Largest Log Combiner

This unit performs the state-metric combine of one radix-4 trellis step, where two consecutive radix-2 steps are merged and two input symbols are retired per clock. Each cycle it takes four candidate log-domain path metrics that merge into one state. All pairwise comparisons among them are evaluated at once. From these results, one path of logic picks the largest metric and another finds the gap between the largest and the runner-up. The output is the largest metric plus a correction taken from a small table indexed by that gap. The two weaker candidates play no part in the result, so the delay stays close to a single two-input log-sum rather than a two-level tree.

Metrics are two's-complement signed values. The result saturates at the largest positive code and is registered, so it appears one clock after the input is presented. Branch metric generation and the surrounding trellis belong to other blocks.

Top module: `r4_best2_combiner`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_metric` is 0 until the first valid input has been registered.
- R2: `out_valid` is `in_valid` delayed by exactly one clock.
- R3: For a valid input, `out_metric` one clock later equals max + corr(gap), where max is the largest of the four metrics, gap = max minus the second largest, and corr is 3 for gap 0..1, 2 for gap 2..3, 1 for gap 4..5 and 0 for gap 6 or more.
- R4: The two smallest metrics have no effect on the result: changing them, while they stay at or below the second largest, leaves `out_metric` unchanged.
- R5: When two or more metrics share the maximum value, the gap is 0 and the full correction of 3 is added.
- R6: The result saturates at +63; a sum above 63 gives 63.
- R7: While `in_valid` is 0, `out_metric` holds its previous value whatever the metric inputs carry.
- R8: Metrics are 7-bit two's complement (-64..+63); path k sits at bits [7k+6:7k] of `in_metrics`, and negative values are ordered below positive ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The four metrics on `in_metrics` are to be combined this cycle |
| in_metrics | input | 28 | Four signed 7-bit candidate path metrics, path k at bits [7k+6:7k] |
| out_valid | output | 1 | `out_metric` carries a fresh result |
| out_metric | output | 7 | Signed combined metric, saturated at +63 |

## Verification
The hardest case to reach from the ports is a set of candidates where ranking mistakes cancel out. That happens with ties at the top, with ties between the second and third place, and with wrong-sign ordering near the -64/+63 boundary. The stimulus table places the maximum in every path position and puts a tie in several position pairs. It sweeps the gap through each correction band edge (1/2, 3/4, 5/6) and mixes negative and positive metrics. Directed steps then change only the two weakest candidates against a fixed pair of leaders, and drive changing metrics with `in_valid` low to show the output holds.

// File: rtl/r4c_pkg.sv
package r4c_pkg;

  // Correction added to the winning metric, indexed by the gap to the
  // runner-up: approximates a scaled log(1 + exp(-gap)) in steps.
  function automatic int corr_of_gap(input int gap, input int cmax, input int step);
    int idx;
    idx = gap / step;
    if (idx >= cmax) return 0;
    return cmax - idx;
  endfunction

  // Upper-saturating sum; the correction is never negative, so no floor.
  function automatic int sat_sum(input int base, input int incr, input int hi);
    int s;
    s = base + incr;
    if (s > hi) return hi;
    return s;
  endfunction

endpackage

// File: rtl/r4c_pair_compare.sv
module r4c_pair_compare #(
  parameter int N_PATHS = 4,
  parameter int MW      = 7
) (
  input  logic [N_PATHS*MW-1:0]      metrics,
  output logic [N_PATHS*N_PATHS-1:0] beats     // bit i*N+j: path i outranks path j
);
  // One comparator per unordered pair; the mirrored entry is its complement.
  // A tie makes the lower index outrank the higher one.
  for (genvar i = 0; i < N_PATHS; i++) begin : g_row
    for (genvar j = 0; j < N_PATHS; j++) begin : g_col
      if (i < j) begin : g_cmp
        logic signed [MW-1:0] a_i, a_j;
        assign a_i = $signed(metrics[i*MW +: MW]);
        assign a_j = $signed(metrics[j*MW +: MW]);
        assign beats[i*N_PATHS+j] = (a_i >= a_j);
      end else if (i > j) begin : g_mirror
        assign beats[i*N_PATHS+j] = ~beats[j*N_PATHS+i];
      end else begin : g_diag
        assign beats[i*N_PATHS+j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/r4c_rank_select.sv
module r4c_rank_select #(
  parameter int N_PATHS = 4,
  parameter int MW      = 7,
  localparam int GW     = MW + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_PATHS*MW-1:0]         metrics,
  input  logic [N_PATHS*N_PATHS-1:0]    beats,
  output logic [N_PATHS-1:0]            max_sel,
  output logic [N_PATHS-1:0]            run_sel,
  output logic signed [MW-1:0]          max_val,
  output logic signed [MW-1:0]          run_val,
  output logic [GW-1:0]                 gap
);
  // Rank of each path = number of paths it outranks.
  for (genvar i = 0; i < N_PATHS; i++) begin : g_rank
    logic [N_PATHS-1:0] row;
    assign row        = beats[i*N_PATHS +: N_PATHS];
    assign max_sel[i] = ($countones(row) == N_PATHS - 1);
    assign run_sel[i] = ($countones(row) == N_PATHS - 2);
  end

  // First logic block: the winning value.
  always_comb begin
    max_val = '0;
    for (int k = 0; k < N_PATHS; k++)
      max_val = max_val | ({MW{max_sel[k]}} & metrics[k*MW +: MW]);
  end

  // Second logic block: runner-up value and gap to the winner.
  always_comb begin
    run_val = '0;
    for (int k = 0; k < N_PATHS; k++)
      run_val = run_val | ({MW{run_sel[k]}} & metrics[k*MW +: MW]);
  end

  logic signed [GW-1:0] max_ext, run_ext;
  assign max_ext = {max_val[MW-1], max_val};
  assign run_ext = {run_val[MW-1], run_val};
  assign gap     = max_ext - run_ext;

  AST_SINGLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(max_sel)) else $error("AST_SINGLE_MAX");                       // R3
  AST_SINGLE_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(run_sel) && ((max_sel & run_sel) == '0)) else $error("AST_SINGLE_RUNNER"); // R4
  AST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    max_val >= run_val) else $error("AST_ORDERED");                         // R8
endmodule

// File: rtl/r4c_corr_add.sv
module r4c_corr_add #(
  parameter int MW        = 7,
  parameter int CORR_MAX  = 3,
  parameter int CORR_STEP = 2,
  localparam int GW       = MW + 1,
  localparam int CW       = $clog2(CORR_MAX + 1),
  localparam int HI       = (1 << (MW - 1)) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [MW-1:0] max_val,
  input  logic [GW-1:0]        gap,
  output logic [CW-1:0]        corr,
  output logic signed [MW-1:0] sum_sat
);
  import r4c_pkg::*;

  always_comb begin
    int c, s;
    c       = corr_of_gap(int'(gap), CORR_MAX, CORR_STEP);
    corr    = CW'(c);
    s       = sat_sum(int'(max_val), c, HI);
    sum_sat = MW'(s);
  end

  AST_TIE_FULL_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == '0) |-> (int'(corr) == CORR_MAX)) else $error("AST_TIE_FULL_CORR"); // R5
  AST_NOT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    sum_sat >= max_val) else $error("AST_NOT_BELOW_MAX");                   // R6
endmodule

// File: rtl/r4_best2_combiner.sv
module r4_best2_combiner #(
  parameter int N_PATHS   = 4,
  parameter int MW        = 7,
  parameter int CORR_MAX  = 3,
  parameter int CORR_STEP = 2,
  localparam int GW       = MW + 1,
  localparam int CW       = $clog2(CORR_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [N_PATHS*MW-1:0] in_metrics,
  output logic                  out_valid,
  output logic [MW-1:0]         out_metric
);
  logic [N_PATHS*N_PATHS-1:0] beats;
  logic [N_PATHS-1:0]         max_sel, run_sel;
  logic signed [MW-1:0]       max_val, run_val, sum_sat;
  logic [GW-1:0]              gap;
  logic [CW-1:0]              corr;

  r4c_pair_compare #(.N_PATHS(N_PATHS), .MW(MW)) u_cmp (
    .metrics(in_metrics), .beats(beats)
  );

  r4c_rank_select #(.N_PATHS(N_PATHS), .MW(MW)) u_rank (
    .clk(clk), .rst_n(rst_n), .metrics(in_metrics), .beats(beats),
    .max_sel(max_sel), .run_sel(run_sel), .max_val(max_val),
    .run_val(run_val), .gap(gap)
  );

  r4c_corr_add #(.MW(MW), .CORR_MAX(CORR_MAX), .CORR_STEP(CORR_STEP)) u_add (
    .clk(clk), .rst_n(rst_n), .max_val(max_val), .gap(gap),
    .corr(corr), .sum_sat(sum_sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_metric <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_metric <= sum_sat;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)) else $error("AST_VALID_LATENCY");         // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_metric)) else $error("AST_HOLD_IDLE");        // R7
  AST_RESULT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($signed(out_metric) >= $past(max_val))) else $error("AST_RESULT_FLOOR"); // R3
endmodule

// File: tb/r4_best2_combiner_test.sv
`timescale 1ns/1ps
module r4_best2_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [27:0] in_metrics = '0;
  logic        out_valid;
  logic [6:0]  out_metric;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  r4_best2_combiner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_metrics(in_metrics),
    .out_valid(out_valid), .out_metric(out_metric)
  );

  // {path3, path2, path1, path0}; expected values worked out from R3/R5/R6/R8.
  localparam int NV = 14;
  localparam logic [27:0] VIN [NV] = '{
    {7'sd5,   7'sd10,  7'sd20,  7'sd1  },  // gap 10 -> +0        : 20
    {7'sd0,   7'sd0,   7'sd11,  7'sd10 },  // gap 1  -> +3        : 14
    {-7'sd5,  7'sd2,   7'sd30,  7'sd30 },  // tie    -> +3        : 33
    {-7'sd40, -7'sd12, -7'sd20, -7'sd10},  // gap 2  -> +2        : -8
    {7'sd0,   7'sd0,   7'sd61,  7'sd62 },  // 62+3 saturates      : 63
    {7'sd63,  7'sd63,  7'sd63,  7'sd63 },  // all tied at top     : 63
    {-7'sd64, -7'sd64, -7'sd64, -7'sd64},  // all tied at bottom  : -61
    {-7'sd64, 7'sd3,   7'sd5,   7'sd0  },  // gap 2               : 7
    {7'sd8,   7'sd9,   7'sd4,   7'sd7  },  // gap 1, max in p2    : 12
    {7'sd0,   7'sd36,  -7'sd64, 7'sd40 },  // gap 4 -> +1         : 41
    {7'sd34,  -7'sd1,  7'sd35,  7'sd40 },  // gap 5 -> +1         : 41
    {7'sd0,   7'sd20,  7'sd34,  7'sd40 },  // gap 6 -> +0         : 40
    {-7'sd64, -7'sd64, -7'sd64, -7'sd1 },  // gap 63              : -1
    {7'sd0,   7'sd0,   -7'sd64, 7'sd63 }   // gap 63 at top       : 63
  };
  localparam logic [6:0] VEXP [NV] = '{
    7'sd20, 7'sd14, 7'sd33, -7'sd8, 7'sd63, 7'sd63, -7'sd61,
    7'sd7, 7'sd12, 7'sd41, 7'sd41, 7'sd40, -7'sd1, 7'sd63
  };
  localparam string VREQ [NV] = '{
    "R3", "R3", "R5", "R8", "R6", "R6", "R5", "R8", "R3", "R3", "R3", "R3", "R8", "R6"
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, one rising edge registers, sample at next falling edge.
  task automatic drive(input logic v, input logic [27:0] m);
    @(negedge clk);
    in_valid   = v;
    in_metrics = m;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R1 valid in reset", out_valid, 1'b0);
    check("R1 metric in reset", out_metric, 7'd0);
    rst_n = 1'b1;
    drive(1'b0, {7'sd9, 7'sd9, 7'sd9, 7'sd9});
    check_bit("R1 valid after reset", out_valid, 1'b0);
    check("R1 metric after reset", out_metric, 7'd0);

    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VIN[k]);
      check_bit("R2 valid follows", out_valid, 1'b1);
      check(VREQ[k], out_metric, VEXP[k]);
    end

    // R4: leaders 11 and 10 fixed, weaker pair varied.
    drive(1'b1, {7'sd9, -7'sd64, 7'sd11, 7'sd10});
    check("R4 weak pair A", out_metric, 7'sd14);
    drive(1'b1, {-7'sd30, 7'sd5, 7'sd11, 7'sd10});
    check("R4 weak pair B", out_metric, 7'sd14);
    drive(1'b1, {7'sd10, 7'sd10, 7'sd11, 7'sd10});
    check("R4 weak pair tied with runner", out_metric, 7'sd14);

    // R5: tie at the max placed in the last two positions.
    drive(1'b1, {7'sd25, 7'sd25, -7'sd3, 7'sd0});
    check("R5 tie high index", out_metric, 7'sd28);

    // R7: metrics change with valid low, output holds, valid drops.
    drive(1'b0, {7'sd0, 7'sd0, 7'sd0, 7'sd50});
    check_bit("R2 valid drops", out_valid, 1'b0);
    check("R7 hold A", out_metric, 7'sd28);
    drive(1'b0, {-7'sd64, 7'sd1, 7'sd2, 7'sd3});
    check("R7 hold B", out_metric, 7'sd28);

    // R1: reset mid-stream clears the output.
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit("R1 valid re-reset", out_valid, 1'b0);
    check("R1 metric re-reset", out_metric, 7'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule